// File: doc/BRIEF.md
# Multistage Barrel Shifter

This block shifts a 32-bit word left or right by any distance from 0 to 31 in a single combinational pass. It is built as a cascade of five multiplexer stages. Each stage either passes its input straight through or moves it by a fixed power of two (1, 2, 4, 8 or 16). The stage for distance 2^k is switched on by bit k of the shift distance, so the five stages together cover every distance without a separate wide multiplexer for each value.

Three kinds of shift are offered: a logical left shift, a logical right shift, and an arithmetic right shift. The arithmetic right shift copies the sign bit into every vacated upper position, which makes the result a division by a power of two that rounds toward minus infinity. The shift distance comes from one of two places: a 5-bit constant taken from an instruction field, or the low five bits of a register value. A one-bit selector chooses between them.

A typical use is to pull a bit field out of a word. The word is first masked, then shifted logically to the right so that the field lands at bit 0.

The block has no state machine, no clock and no reset. The data path is a chain of combinational stages with no named states or transitions.

Top module: `barrel_shift32`

## Requirements
- R1: With `shift_kind_i` = 2'b00, `result_o` equals `operand_i` shifted left by the selected distance, with zeros entering at bit 0.
- R2: With `shift_kind_i` = 2'b10, `result_o` equals `operand_i` shifted right by the selected distance, with zeros entering at bit 31.
- R3: With `shift_kind_i` = 2'b11, `result_o` equals `operand_i` shifted right by the selected distance, with every vacated upper bit equal to `operand_i[31]`. Read as two's complement, this result equals floor(operand / 2^distance).
- R4: When `shift_kind_i[1]` is 0, `shift_kind_i[0]` has no effect: the code 2'b01 gives the same result as 2'b00.
- R5: A selected distance of 0 returns `operand_i` unchanged for every value of `shift_kind_i`.
- R6: With `amt_from_reg_i` = 0, the distance is `imm_amt_i`. With `amt_from_reg_i` = 1, the distance is `reg_amt_i[4:0]`, and `reg_amt_i[31:5]` has no effect on `result_o`.
- R7: At distance 31, a left shift leaves only the original bit 0, now at bit 31. A logical right shift leaves only the original bit 31, now at bit 0. An arithmetic right shift gives a word in which every bit equals `operand_i[31]`.
- R8: A word masked to its bits 15..10 and shifted logically right by 10 gives that 6-bit field at bits 5..0, a value from 0 to 63, with zeros above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Word to be shifted |
| shift_kind_i | input | 2 | Shift kind: 00 left logical, 01 same as 00, 10 right logical, 11 right arithmetic |
| amt_from_reg_i | input | 1 | Distance source: 0 = `imm_amt_i`, 1 = `reg_amt_i[4:0]` |
| imm_amt_i | input | 5 | Constant shift distance from an instruction field |
| reg_amt_i | input | 32 | Register value whose low five bits give the distance |
| result_o | output | 32 | Shifted word |

## Verification
The bench targets the following corner cases and the faults each one would expose:

- **Distances 0 and 31, and distances that use only one stage.** A stage wired to the wrong offset, or to the wrong bit of the distance, gives a wrong result for exactly the distances that use that stage.
- **Negative operands under the arithmetic right shift.** A design that filled with zeros here would turn negative quotients into large positive values.
- **The code 01 and the upper register bits (31:5).** Both are varied while everything else is held constant. A design that decoded the code 01 as a right shift, or took more than five bits of the register as the distance, would change its output.
- **Extracting the bit field at bits 15..10.** This shows whether the logical right shift puts zeros above the extracted field.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned AMT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SK_LSL     = 2'b00,
        SK_LSL_ALT = 2'b01,
        SK_LSR     = 2'b10,
        SK_ASR     = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
    parameter int unsigned AMT_W = 5,
    parameter int unsigned REG_W = 32
) (
    input  logic             from_reg_i,
    input  logic [AMT_W-1:0] imm_i,
    input  logic [REG_W-1:0] reg_i,
    output logic [AMT_W-1:0] amt_o
);
    logic unused_reg_hi;

    assign unused_reg_hi = ^reg_i[REG_W-1:AMT_W];

    always_comb begin
        if (from_reg_i) begin
            amt_o = reg_i[AMT_W-1:0];
        end else begin
            amt_o = imm_i;
        end
    end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DIST  = 1
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             en_i,
    input  logic             left_i,
    input  logic             fill_i,
    output logic [WIDTH-1:0] data_o
);
    always_comb begin
        if (!en_i) begin
            data_o = data_i;
        end else if (left_i) begin
            data_o = {data_i[WIDTH-1-DIST:0], {DIST{1'b0}}};
        end else begin
            data_o = {{DIST{fill_i}}, data_i[WIDTH-1:DIST]};
        end
    end
endmodule

// File: rtl/barrel_shift32.sv
module barrel_shift32
    import shf_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [1:0]       shift_kind_i,
    input  logic             amt_from_reg_i,
    input  logic [SHW-1:0]   imm_amt_i,
    input  logic [WIDTH-1:0] reg_amt_i,
    output logic [WIDTH-1:0] result_o
);
    localparam int unsigned NSTAGE = SHW;

    shift_kind_e      kind;
    logic [SHW-1:0]   amt;
    logic             go_left;
    logic             fill_bit;
    logic [WIDTH-1:0] stg [0:NSTAGE];

    assign kind     = shift_kind_e'(shift_kind_i);
    assign go_left  = (kind == SK_LSL) || (kind == SK_LSL_ALT);
    assign fill_bit = (kind == SK_ASR) ? operand_i[WIDTH-1] : 1'b0;

    shf_amt_sel #(
        .AMT_W (SHW),
        .REG_W (WIDTH)
    ) u_amt (
        .from_reg_i (amt_from_reg_i),
        .imm_i      (imm_amt_i),
        .reg_i      (reg_amt_i),
        .amt_o      (amt)
    );

    assign stg[0] = operand_i;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        shf_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) u_stage (
            .data_i (stg[k]),
            .en_i   (amt[k]),
            .left_i (go_left),
            .fill_i (fill_bit),
            .data_o (stg[k+1])
        );
    end

    assign result_o = stg[NSTAGE];

    always_comb begin
        if (amt == '0) begin
            a_r5_zero_amt_identity: assert (result_o == operand_i)
                else $error("R5 zero distance changed the operand");
        end
        if (kind == SK_ASR) begin
            a_r3_sign_kept: assert (result_o[WIDTH-1] == operand_i[WIDTH-1])
                else $error("R3 arithmetic shift lost the sign bit");
        end
        if (kind == SK_LSR && amt != '0) begin
            a_r2_zero_top: assert (result_o[WIDTH-1] == 1'b0)
                else $error("R2 logical right shift filled a one at the top");
            a_r2_ones_not_grown: assert ($countones(result_o) <= $countones(operand_i))
                else $error("R2 logical right shift created set bits");
        end
        if (go_left && amt != '0) begin
            a_r1_zero_bottom: assert (result_o[0] == 1'b0)
                else $error("R1 left shift filled a one at bit 0");
        end
    end
endmodule

// File: tb/barrel_shift32_tb.sv
module barrel_shift32_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand;
    logic [1:0]  kind;
    logic        from_reg;
    logic [4:0]  imm_amt;
    logic [31:0] reg_amt;
    logic [31:0] result;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    barrel_shift32 u_dut (
        .operand_i      (operand),
        .shift_kind_i   (kind),
        .amt_from_reg_i (from_reg),
        .imm_amt_i      (imm_amt),
        .reg_amt_i      (reg_amt),
        .result_o       (result)
    );

    function automatic logic [31:0] model(input logic [31:0] op, input logic [1:0] k,
                                          input logic [4:0] d);
        if (!k[1]) return op << d;
        if (k[0]) return 32'($signed(op) >>> d);
        return op >> d;
    endfunction

    function automatic logic [4:0] pick_amt(input logic fr, input logic [4:0] im,
                                            input logic [31:0] rg);
        return fr ? rg[4:0] : im;
    endfunction

    task automatic apply(input logic [31:0] op, input logic [1:0] k, input logic fr,
                         input logic [4:0] im, input logic [31:0] rg);
        @(posedge clk);
        #1;
        operand = op; kind = k; from_reg = fr; imm_amt = im; reg_amt = rg;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog R1 act=%0d exp<=100000 cycles", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] keep;
        operand = '0; kind = 2'b00; from_reg = 1'b0; imm_amt = '0; reg_amt = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R5 reset-state all zero", result, 32'h0);

        // R5: zero distance in every kind
        for (int k = 0; k < 4; k++) begin
            apply(32'hDEAD_BEEF, 2'(k), 1'b0, 5'd0, 32'hFFFF_FFE0);
            check("R5 zero distance", result, 32'hDEAD_BEEF);
        end

        // R1/R2/R3: single-stage distances
        for (int s = 0; s < 5; s++) begin
            apply(32'h8000_0001, 2'b00, 1'b0, 5'(1 << s), '0);
            check("R1 single stage", result, model(32'h8000_0001, 2'b00, 5'(1 << s)));
            apply(32'h8000_0001, 2'b10, 1'b0, 5'(1 << s), '0);
            check("R2 single stage", result, model(32'h8000_0001, 2'b10, 5'(1 << s)));
            apply(32'h8000_0001, 2'b11, 1'b0, 5'(1 << s), '0);
            check("R3 single stage", result, model(32'h8000_0001, 2'b11, 5'(1 << s)));
        end

        // R7: distance 31
        apply(32'h0000_0001, 2'b00, 1'b0, 5'd31, '0);
        check("R7 left 31", result, 32'h8000_0000);
        apply(32'h8000_0000, 2'b10, 1'b0, 5'd31, '0);
        check("R7 logical right 31", result, 32'h0000_0001);
        apply(32'h8000_0000, 2'b11, 1'b0, 5'd31, '0);
        check("R7 arithmetic right 31 negative", result, 32'hFFFF_FFFF);
        apply(32'h7FFF_FFFF, 2'b11, 1'b0, 5'd31, '0);
        check("R7 arithmetic right 31 positive", result, 32'h0);

        // R3: floor division of a negative value
        apply(32'hFFFF_FFF9, 2'b11, 1'b0, 5'd1, '0);
        check("R3 -7 div 2 floor", result, 32'hFFFF_FFFC);

        // R4: code 01 equals code 00
        apply(32'h1234_5678, 2'b00, 1'b0, 5'd7, '0);
        keep = result;
        apply(32'h1234_5678, 2'b01, 1'b0, 5'd7, '0);
        check("R4 kind 01 same as 00", result, keep);

        // R6: register source, upper bits ignored, immediate not used
        apply(32'hA5A5_0F0F, 2'b10, 1'b1, 5'd2, 32'h0000_0009);
        check("R6 register distance", result, 32'hA5A5_0F0F >> 9);
        apply(32'hA5A5_0F0F, 2'b10, 1'b1, 5'd17, 32'hFFFF_FFE9);
        check("R6 register upper bits ignored", result, 32'hA5A5_0F0F >> 9);
        apply(32'hA5A5_0F0F, 2'b10, 1'b0, 5'd4, 32'hFFFF_FFE9);
        check("R6 immediate distance", result, 32'hA5A5_0F0F >> 4);

        // R8: field extraction at bits 15..10
        apply(32'hFFFF_FFFF & 32'h0000_FC00, 2'b10, 1'b0, 5'd10, '0);
        check("R8 field all ones", result, 32'd63);
        apply(32'h9ABC_DEF0 & 32'h0000_FC00, 2'b10, 1'b0, 5'd10, '0);
        check("R8 field pattern", result, 32'((32'h9ABC_DEF0 >> 10) & 32'h3F));

        // Random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] op;
            logic [31:0] rg;
            logic [1:0]  k;
            logic [4:0]  im;
            logic        fr;
            op = $urandom(); rg = $urandom(); k = 2'($urandom()); im = 5'($urandom());
            fr = 1'($urandom());
            apply(op, k, fr, im, rg);
            check(k[1] ? (k[0] ? "R3 random" : "R2 random") : "R1 random", result,
                  model(op, k, pick_amt(fr, im, rg)));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule